// File: doc/BRIEF.md
# Address translation mode selector

This block sits at the front of the address translation path. On each access it picks one of four outcomes. The access can bypass translation entirely. It can hit one of several direct-map windows. It can be handed on to the TLB for a page lookup. Or it can be refused as a malformed address. The inputs are the full-width virtual address, the current privilege level and two mode bits, one that forces untranslated addressing and one that enables paging. A bank of window configuration words, each one full address wide, is also an input.

A direct-map window covers one segment of the address space. The segment is named by the address bits above the virtual-space width. Each window carries separate enables for the most privileged level and the least privileged level. A window hit rebuilds the physical address by putting the window's physical segment field on top of the low virtual-address bits. An access that hits no window must have a canonical upper part before the TLB is asked to translate it. The decision is registered and appears one cycle after the request, with a valid flag. The TLB and the delivery of faults belong to other blocks.

Top module: `xlat_mode_sel`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. While `out_valid` is low, `out_kind`, `out_paddr`, `out_perm`, `out_win` and `out_tlb_va` are all zero.
- R2: If `in_da` is high, or `in_pg` is low, the result is untranslated. `out_kind` is 2'b00, `out_paddr` is `in_va[PA_W-1:0]` and `out_perm` is 3'b111 (read, write, execute). The window bank and the upper address bits have no effect in this case.
- R3: Window g is enabled at level 0 by bit KEN_BIT (default 0) of its configuration word, and at level 3 by bit UEN_BIT (default 3). Levels 1 and 2 never hit a window. An enabled window hits when `in_va[ADDR_W-1:VA_W]` equals bits [ADDR_W-1:VA_W] of its word.
- R4: Window hits are resolved by index, and the lowest index wins. Windows are tested before the canonical-address check, so a window whose segment is all zeros still wins over a TLB lookup.
- R5: A window hit gives `out_kind` 2'b01, `out_perm` 3'b111 and `out_win` equal to the window index. `out_paddr` is the PSEG_W-bit field at PSEG_LSB (default bits 27:24) of the word, placed above `in_va[PA_W-PSEG_W-1:0]`.
- R6: With no window hit and bits [ADDR_W-1:VA_W] all zeros or all ones, the result is a TLB request. `out_kind` is 2'b10, `out_tlb_va` is `in_va[VA_W-1:0]`, and `out_paddr`, `out_perm` and `out_win` are zero.
- R7: With no window hit and bits [ADDR_W-1:VA_W] mixed, the result is a bad-address fault. `out_kind` is 2'b11 and every other data output is zero.
- R8: After reset and before the first request, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_va | input | ADDR_W | Virtual address |
| in_plv | input | PLV_W | Current privilege level (0 most privileged) |
| in_da | input | 1 | Untranslated-addressing mode |
| in_pg | input | 1 | Paging enable |
| win_cfg | input | N_WIN*ADDR_W | Window configuration words, window g at [g*ADDR_W +: ADDR_W] |
| out_valid | output | 1 | Result present |
| out_kind | output | 2 | 00 untranslated, 01 window, 10 TLB request, 11 fault |
| out_paddr | output | PA_W | Physical address for kinds 00 and 01 |
| out_perm | output | 3 | Permissions {read, write, execute} |
| out_win | output | IDX_W | Index of the window that hit |
| out_tlb_va | output | VA_W | Address passed to the TLB for kind 10 |

## Verification
The block keeps no state other than the registered result. A wrong internal decision therefore shows at the ports in the very cycle after the request that caused it, as a wrong kind, a wrong segment field in the physical address, or the wrong window index. The bench aims its directed cases at the decisions most likely to go wrong: windows that overlap, with different level enables; the middle privilege levels; a window whose segment is zero; and mode-bit combinations in which paging is off. A fresh window bank is then loaded every forty cycles and mixed addresses are applied, each compared against the behavioural model on the cycle it appears.

// File: rtl/xms_pkg.sv
package xms_pkg;

    typedef enum logic [1:0] {
        XK_DIRECT = 2'b00,
        XK_WINDOW = 2'b01,
        XK_LOOKUP = 2'b10,
        XK_FAULT  = 2'b11
    } xk_e;

    localparam logic [2:0] PERM_ALL  = 3'b111;
    localparam logic [2:0] PERM_NONE = 3'b000;

endpackage

// File: rtl/xms_win_match.sv
module xms_win_match #(
    parameter int ADDR_W   = 64,
    parameter int VA_W     = 48,
    parameter int PA_W     = 48,
    parameter int PLV_W    = 2,
    parameter int PSEG_LSB = 24,
    parameter int PSEG_W   = 4,
    parameter int KEN_BIT  = 0,
    parameter int UEN_BIT  = 3
) (
    input  logic [ADDR_W-1:0] va,
    input  logic [PLV_W-1:0]  plv,
    input  logic [ADDR_W-1:0] cfg,
    output logic              hit,
    output logic [PA_W-1:0]   pa
);
    localparam int SEG_W = ADDR_W - VA_W;
    localparam int LOW_W = PA_W - PSEG_W;
    localparam logic [PLV_W-1:0] PLV_TOP = '1;

    logic             lvl_en;
    logic [SEG_W-1:0] va_seg;
    logic [SEG_W-1:0] cfg_seg;

    assign va_seg  = va[ADDR_W-1:VA_W];
    assign cfg_seg = cfg[ADDR_W-1:VA_W];

    always_comb begin
        if (plv == '0) begin
            lvl_en = cfg[KEN_BIT];
        end else if (plv == PLV_TOP) begin
            lvl_en = cfg[UEN_BIT];
        end else begin
            lvl_en = 1'b0;
        end
    end

    assign hit = lvl_en && (va_seg == cfg_seg);
    assign pa  = {cfg[PSEG_LSB +: PSEG_W], va[LOW_W-1:0]};

endmodule

// File: rtl/xms_first_hit.sv
module xms_first_hit #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xms_ext_check.sv
module xms_ext_check #(
    parameter int ADDR_W = 64,
    parameter int VA_W   = 48
) (
    input  logic [ADDR_W-1:0] va,
    output logic              canon
);
    localparam int SEG_W = ADDR_W - VA_W;

    logic [SEG_W-1:0] upper;

    assign upper = va[ADDR_W-1:VA_W];
    assign canon = (&upper) || !(|upper);
endmodule

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel
    import xms_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int VA_W     = 48,
    parameter int PA_W     = 48,
    parameter int N_WIN    = 4,
    parameter int PLV_W    = 2,
    parameter int PSEG_LSB = 24,
    parameter int PSEG_W   = 4,
    parameter int KEN_BIT  = 0,
    parameter int UEN_BIT  = 3,
    localparam int IDX_W   = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [ADDR_W-1:0]       in_va,
    input  logic [PLV_W-1:0]        in_plv,
    input  logic                    in_da,
    input  logic                    in_pg,
    input  logic [N_WIN*ADDR_W-1:0] win_cfg,
    output logic                    out_valid,
    output logic [1:0]              out_kind,
    output logic [PA_W-1:0]         out_paddr,
    output logic [2:0]              out_perm,
    output logic [IDX_W-1:0]        out_win,
    output logic [VA_W-1:0]         out_tlb_va
);

    typedef struct packed {
        logic             valid;
        xk_e              kind;
        logic [PA_W-1:0]  paddr;
        logic [2:0]       perm;
        logic [IDX_W-1:0] win;
        logic [VA_W-1:0]  tlb_va;
    } res_t;

    res_t st_d, st_q;

    logic [N_WIN-1:0] win_hit;
    logic [PA_W-1:0]  win_pa [N_WIN];
    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;
    logic             canon;

    // One comparator per window
    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        xms_win_match #(
            .ADDR_W  (ADDR_W),
            .VA_W    (VA_W),
            .PA_W    (PA_W),
            .PLV_W   (PLV_W),
            .PSEG_LSB(PSEG_LSB),
            .PSEG_W  (PSEG_W),
            .KEN_BIT (KEN_BIT),
            .UEN_BIT (UEN_BIT)
        ) u_match (
            .va (in_va),
            .plv(in_plv),
            .cfg(win_cfg[g*ADDR_W +: ADDR_W]),
            .hit(win_hit[g]),
            .pa (win_pa[g])
        );
    end

    xms_first_hit #(
        .N    (N_WIN),
        .IDX_W(IDX_W)
    ) u_first (
        .hits(win_hit),
        .any (any_hit),
        .idx (hit_idx)
    );

    xms_ext_check #(
        .ADDR_W(ADDR_W),
        .VA_W  (VA_W)
    ) u_ext (
        .va   (in_va),
        .canon(canon)
    );

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.valid = 1'b1;
            if (in_da || !in_pg) begin
                st_d.kind  = XK_DIRECT;
                st_d.paddr = in_va[PA_W-1:0];
                st_d.perm  = PERM_ALL;
            end else if (any_hit) begin
                st_d.kind  = XK_WINDOW;
                st_d.paddr = win_pa[hit_idx];
                st_d.perm  = PERM_ALL;
                st_d.win   = hit_idx;
            end else if (canon) begin
                st_d.kind   = XK_LOOKUP;
                st_d.tlb_va = in_va[VA_W-1:0];
            end else begin
                st_d.kind = XK_FAULT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_kind   = st_q.kind;
    assign out_paddr  = st_q.paddr;
    assign out_perm   = st_q.perm;
    assign out_win    = st_q.win;
    assign out_tlb_va = st_q.tlb_va;

endmodule

// File: rtl/xms_checker.sv
module xms_checker #(
    parameter int ADDR_W = 64,
    parameter int VA_W   = 48,
    parameter int PA_W   = 48,
    parameter int PLV_W  = 2,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_va,
    input logic [PLV_W-1:0]  in_plv,
    input logic              in_da,
    input logic              in_pg,
    input logic              out_valid,
    input logic [1:0]        out_kind,
    input logic [PA_W-1:0]   out_paddr,
    input logic [2:0]        out_perm,
    input logic [IDX_W-1:0]  out_win,
    input logic [VA_W-1:0]   out_tlb_va
);
    logic upper_mixed;
    logic mid_level;
    logic untranslated;

    assign upper_mixed  = !((&in_va[ADDR_W-1:VA_W]) || !(|in_va[ADDR_W-1:VA_W]));
    assign mid_level    = (in_plv != '0) && (in_plv != '1);
    assign untranslated = in_da || !in_pg;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_kind == 2'b00 && out_perm == 3'b000
                       && out_paddr == '0 && out_win == '0 && out_tlb_va == '0));

    a_r2_untranslated: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && untranslated) |=>
            (out_kind == 2'b00 && out_perm == 3'b111
             && out_paddr == $past(in_va[PA_W-1:0])));

    a_r3_mid_level_no_window: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !untranslated && mid_level) |=> out_kind != 2'b01);

    a_r5_window_perm: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'b01) |-> (out_perm == 3'b111 && out_tlb_va == '0));

    a_r6_lookup_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'b10) |->
            (out_perm == 3'b000 && out_paddr == '0 && out_win == '0
             && !$past(upper_mixed)));

    a_r7_fault_mixed: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'b11) |->
            ($past(upper_mixed) && out_perm == 3'b000 && out_paddr == '0
             && out_tlb_va == '0));

endmodule

bind xlat_mode_sel xms_checker #(
    .ADDR_W(ADDR_W),
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .PLV_W (PLV_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_va     (in_va),
    .in_plv    (in_plv),
    .in_da     (in_da),
    .in_pg     (in_pg),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_paddr (out_paddr),
    .out_perm  (out_perm),
    .out_win   (out_win),
    .out_tlb_va(out_tlb_va)
);

// File: tb/xlat_mode_sel_tb.sv
`timescale 1ns/1ps
module xlat_mode_sel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_va = '0;
    logic [1:0]  in_plv = '0;
    logic        in_da = 1'b0;
    logic        in_pg = 1'b1;
    logic [63:0] cfg [4];
    logic [255:0] win_cfg;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [47:0] out_paddr;
    logic [2:0]  out_perm;
    logic [1:0]  out_win;
    logic [47:0] out_tlb_va;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 0;

    typedef struct packed {
        logic        valid;
        logic [1:0]  kind;
        logic [47:0] paddr;
        logic [2:0]  perm;
        logic [1:0]  win;
        logic [47:0] tva;
    } exp_t;

    always #2 clk = ~clk;

    assign win_cfg = {cfg[3], cfg[2], cfg[1], cfg[0]};

    xlat_mode_sel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_va     (in_va),
        .in_plv    (in_plv),
        .in_da     (in_da),
        .in_pg     (in_pg),
        .win_cfg   (win_cfg),
        .out_valid (out_valid),
        .out_kind  (out_kind),
        .out_paddr (out_paddr),
        .out_perm  (out_perm),
        .out_win   (out_win),
        .out_tlb_va(out_tlb_va)
    );

    function automatic logic [63:0] mkcfg(input logic [15:0] seg, input logic [3:0] pseg,
                                          input logic ken, input logic uen);
        logic [63:0] w;
        w = 64'(seg) << 48;
        w = w | (64'(pseg) << 24);
        w = w | (64'(uen) << 3) | 64'(ken);
        return w;
    endfunction

    // Behavioural reference, written from the requirements
    function automatic exp_t model(input logic v, input logic [63:0] va, input logic [1:0] plv,
                                   input logic da, input logic pg);
        exp_t e;
        logic [15:0] top;
        bit found;
        e = '0;
        found = 0;
        if (!v) return e;
        e.valid = 1;
        top = va[63:48];
        if (da || !pg) begin
            e.kind = 2'd0; e.paddr = va[47:0]; e.perm = 3'b111;
            return e;
        end
        for (int i = 0; i < 4; i++) begin
            logic en;
            en = (plv == 2'd0 && cfg[i][0]) || (plv == 2'd3 && cfg[i][3]);
            if (!found && en && cfg[i][63:48] == top) begin
                found = 1;
                e.kind = 2'd1; e.perm = 3'b111; e.win = 2'(i);
                e.paddr = {cfg[i][27:24], va[43:0]};
            end
        end
        if (found) return e;
        if (top == 16'h0000 || top == 16'hffff) begin
            e.kind = 2'd2; e.tva = va[47:0];
        end else begin
            e.kind = 2'd3;
        end
        return e;
    endfunction

    task automatic compare(input string tag, input exp_t e);
        exp_t a;
        a = {out_valid, out_kind, out_paddr, out_perm, out_win, out_tlb_va};
        nvec++;
        if (a !== e) begin
            nfail++;
            $display("FAIL %s: got v=%0b k=%0d pa=%h perm=%b win=%0d tva=%h, expected v=%0b k=%0d pa=%h perm=%b win=%0d tva=%h",
                     tag, a.valid, a.kind, a.paddr, a.perm, a.win, a.tva,
                     e.valid, e.kind, e.paddr, e.perm, e.win, e.tva);
        end
    endtask

    task automatic step(input string tag, input logic v, input logic [63:0] va,
                        input logic [1:0] plv, input logic da, input logic pg);
        exp_t e;
        @(negedge clk);
        in_valid = v; in_va = va; in_plv = plv; in_da = da; in_pg = pg;
        e = model(v, va, plv, da, pg);
        @(posedge clk);
        #1;
        compare(tag, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        cfg[0] = mkcfg(16'h9000, 4'h1, 1'b1, 1'b0);
        cfg[1] = mkcfg(16'hA000, 4'h2, 1'b0, 1'b1);
        cfg[2] = mkcfg(16'hA000, 4'h3, 1'b1, 1'b1);
        cfg[3] = mkcfg(16'hB000, 4'h5, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        compare("R8 reset state", '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        compare("R8 after release", '0);

        step("R1 idle",               1'b0, 64'h9000_1234_5678_9abc, 2'd0, 1'b0, 1'b1);
        step("R2 da set",             1'b1, 64'h9000_1234_5678_9abc, 2'd0, 1'b1, 1'b1);
        step("R2 paging off",         1'b1, 64'h1234_fedc_ba98_7654, 2'd3, 1'b0, 1'b0);
        step("R2 both set",           1'b1, 64'hB000_0000_0000_0040, 2'd1, 1'b1, 1'b0);
        step("R3 R5 kernel window 0", 1'b1, 64'h9000_0fff_1234_5678, 2'd0, 1'b0, 1'b1);
        step("R3 R7 user no enable",  1'b1, 64'h9000_0fff_1234_5678, 2'd3, 1'b0, 1'b1);
        step("R3 level 1 no window",  1'b1, 64'hA000_0000_0000_1000, 2'd1, 1'b0, 1'b1);
        step("R3 level 2 no window",  1'b1, 64'hA000_0000_0000_1000, 2'd2, 1'b0, 1'b1);
        step("R4 user picks win 1",   1'b1, 64'hA000_8765_4321_0000, 2'd3, 1'b0, 1'b1);
        step("R4 kernel picks win 2", 1'b1, 64'hA000_8765_4321_0000, 2'd0, 1'b0, 1'b1);
        step("R5 window 3",           1'b1, 64'hB000_ffff_ffff_ffff, 2'd0, 1'b0, 1'b1);
        step("R6 lookup upper zero",  1'b1, 64'h0000_8000_0000_1000, 2'd3, 1'b0, 1'b1);
        step("R6 lookup upper ones",  1'b1, 64'hffff_0000_0000_2000, 2'd0, 1'b0, 1'b1);
        step("R7 fault low bit",      1'b1, 64'h0001_0000_0000_0000, 2'd0, 1'b0, 1'b1);
        step("R7 fault top bit",      1'b1, 64'h8000_7fff_ffff_ffff, 2'd3, 1'b0, 1'b1);
        step("R1 idle after burst",   1'b0, 64'h0, 2'd0, 1'b0, 1'b1);
        cfg[3] = mkcfg(16'h0000, 4'hC, 1'b1, 1'b0);
        step("R4 zero segment window",1'b1, 64'h0000_1234_5678_9abc, 2'd0, 1'b0, 1'b1);
        step("R6 zero segment user",  1'b1, 64'h0000_1234_5678_9abc, 2'd3, 1'b0, 1'b1);

        for (int blk = 0; blk < 10; blk++) begin
            logic [15:0] segs [4];
            for (int w = 0; w < 4; w++) begin
                segs[w] = ($urandom % 4 == 0) ? 16'h0000 : 16'(16'h8000 + ($urandom % 6) * 16'h1000);
                cfg[w] = mkcfg(segs[w], 4'($urandom), 1'($urandom), 1'($urandom));
            end
            for (int k = 0; k < 40; k++) begin
                logic [63:0] va;
                int sel;
                va = {$urandom, $urandom};
                sel = $urandom % 5;
                if (sel == 0) va[63:48] = 16'h0000;
                else if (sel == 1) va[63:48] = 16'hffff;
                else if (sel < 4) va[63:48] = segs[$urandom % 4];
                step("R3 R4 R5 R6 R7 mixed", 1'($urandom % 8 != 0), va, 2'($urandom),
                     1'($urandom % 10 == 0), 1'($urandom % 10 != 0));
            end
        end
        step("R1 final idle", 1'b0, 64'h0, 2'd0, 1'b0, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule